// File: doc/BRIEF.md
# Tri-state phase-frequency comparator

This block is the phase detector of a clocked digital PLL. It takes a reference signal and a feedback signal, both single-bit and asynchronous to the fast system clock. It brings each into the clock domain and finds the rising edges of each. From those edges a small state machine makes a three-state error output. The error is given as a drive-enable and a drive-level pair: driven high while the reference leads, driven low while the feedback leads, and released (high impedance) otherwise.

A companion pulse output is high whenever the error is released, so it serves as a lock indicator. Because only rising edges count, input duty cycle does not affect the main error. Two auxiliary detectors are produced alongside it. One is an exclusive-OR of the synchronised inputs. The other is a set/reset flip-flop that reference edges set and feedback edges clear. The loop filter, oscillator and dividers live outside this block.

Top module: `pfd_tristate`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its idle state: `err_oe`=0, `err_lvl`=0, `lock_pulse`=1 and `sr_err`=0.
- R2: A rising edge on an input reaches `err_oe`/`err_lvl`/`sr_err` on the third rising clock edge after the input changes. The XOR output follows an input change on the second edge.
- R3: From the released state, a reference rising edge alone sets `err_oe`=1, `err_lvl`=1. This holds until the next feedback rising edge, which releases the output (`err_oe`=0).
- R4: From the released state, a feedback rising edge alone sets `err_oe`=1, `err_lvl`=0. This holds until the next reference rising edge, which releases the output.
- R5: Further rising edges of the same input that started a drive keep that drive. In particular, a feedback-only edge stream with no reference keeps the error driven low.
- R6: Falling edges and steady levels never change `err_oe` or `err_lvl`.
- R7: `lock_pulse` equals the inverse of `err_oe` in every cycle. `err_lvl` is 0 whenever `err_oe` is 0.
- R8: Rising edges on both inputs in the same clock cycle leave the error released, whatever the previous state.
- R9: `xor_err` is the exclusive OR of the two synchronised inputs.
- R10: In `sr_err`, a reference rising edge alone sets it to 1. A feedback rising edge alone clears it to 0. Simultaneous edges hold its value.
- R11: A reference pulse only one clock cycle wide counts as a valid rising edge and starts a high drive. The drive lasts until a feedback edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Feedback signal, asynchronous |
| err_oe | output | 1 | Main error drive-enable (0 = high impedance) |
| err_lvl | output | 1 | Main error drive level when enabled |
| lock_pulse | output | 1 | High while the main error is released |
| xor_err | output | 1 | Exclusive-OR phase error |
| sr_err | output | 1 | Set/reset phase error |

## Verification
Some rules are checked by assertions in every cycle, using the internal edge strobes: the lock pulse matching the released state, the transitions of the state machine on a lone edge, the release on simultaneous edges, holding with no edges, and the set/reset hold. The bench scenarios are what show the end-to-end behaviour. These cover the exact three-edge latency, a feedback-only stream keeping the drive low, a single-cycle reference glitch, and duty-cycle independence over a full walk of level patterns.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    PD_REL = 2'd0,
    PD_UP  = 2'd1,
    PD_DN  = 2'd2
  } pd_state_t;

  // next state of the tri-state comparator from the current state and edge strobes
  function automatic pd_state_t pd_next(input pd_state_t cur, input logic r_edge, input logic f_edge);
    pd_state_t nxt;
    nxt = cur;
    if (r_edge && f_edge) begin
      nxt = PD_REL;
    end else if (r_edge) begin
      nxt = (cur == PD_DN) ? PD_REL : PD_UP;
    end else if (f_edge) begin
      nxt = (cur == PD_UP) ? PD_REL : PD_DN;
    end
    return nxt;
  endfunction

  // next value of the set/reset detector
  function automatic logic sr_next(input logic cur, input logic r_edge, input logic f_edge);
    logic nxt;
    nxt = cur;
    if (r_edge && !f_edge) nxt = 1'b1;
    else if (f_edge && !r_edge) nxt = 1'b0;
    return nxt;
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic sync,
  output logic rise
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;
  logic         last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[TOP-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= chain[TOP];
  end

  assign sync = chain[TOP];
  assign rise = chain[TOP] & ~last;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic r_edge,
  input  logic f_edge,
  output logic drv_en,
  output logic drv_hi,
  output logic released
);
  pd_state_t state;

  always_ff @(posedge clk) begin
    if (rst) state <= PD_REL;
    else     state <= pd_next(state, r_edge, f_edge);
  end

  assign drv_en   = (state != PD_REL);
  assign drv_hi   = (state == PD_UP);
  assign released = (state == PD_REL);
endmodule

// File: rtl/pfd_aux.sv
module pfd_aux
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic r_sync,
  input  logic f_sync,
  input  logic r_edge,
  input  logic f_edge,
  output logic x_out,
  output logic sr_out
);
  logic sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= 1'b0;
    else     sr_q <= sr_next(sr_q, r_edge, f_edge);
  end

  assign x_out  = r_sync ^ f_sync;
  assign sr_out = sr_q;
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic err_oe,
  output logic err_lvl,
  output logic lock_pulse,
  output logic xor_err,
  output logic sr_err
);
  // named internal events, visible to the bound checker
  logic ref_sync, fb_sync;
  logic ref_rise, fb_rise;

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk), .rst(rst), .din(ref_in), .sync(ref_sync), .rise(ref_rise)
  );

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
    .clk(clk), .rst(rst), .din(fb_in), .sync(fb_sync), .rise(fb_rise)
  );

  pfd_core u_core (
    .clk(clk), .rst(rst), .r_edge(ref_rise), .f_edge(fb_rise),
    .drv_en(err_oe), .drv_hi(err_lvl), .released(lock_pulse)
  );

  pfd_aux u_aux (
    .clk(clk), .rst(rst), .r_sync(ref_sync), .f_sync(fb_sync),
    .r_edge(ref_rise), .f_edge(fb_rise), .x_out(xor_err), .sr_out(sr_err)
  );
endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk (
  input logic clk,
  input logic rst,
  input logic ref_rise,
  input logic fb_rise,
  input logic err_oe,
  input logic err_lvl,
  input logic lock_pulse,
  input logic sr_err
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!err_oe && !err_lvl && lock_pulse && !sr_err));

  // R7
  lock_match_chk: assert property (@(posedge clk) disable iff (rst) (lock_pulse == !err_oe) && (err_oe || !err_lvl));

  // R3
  ref_lead_chk: assert property (@(posedge clk) disable iff (rst) (ref_rise && !fb_rise && !err_oe) |=> (err_oe && err_lvl));

  // R4
  fb_lead_chk: assert property (@(posedge clk) disable iff (rst) (fb_rise && !ref_rise && !err_oe) |=> (err_oe && !err_lvl));

  // R8
  both_edge_chk: assert property (@(posedge clk) disable iff (rst) (ref_rise && fb_rise) |=> !err_oe);

  // R6
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst) (!ref_rise && !fb_rise) |=> ($stable(err_oe) && $stable(err_lvl)));

  // R5
  up_keep_chk: assert property (@(posedge clk) disable iff (rst) (err_oe && err_lvl && !fb_rise) |=> (err_oe && err_lvl));

  // R10
  sr_hold_chk: assert property (@(posedge clk) disable iff (rst) (ref_rise && fb_rise) |=> $stable(sr_err));
endmodule

bind pfd_tristate pfd_tristate_chk u_chk (
  .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
  .err_oe(err_oe), .err_lvl(err_lvl), .lock_pulse(lock_pulse), .sr_err(sr_err)
);

// File: tb/sim_pfd_tristate.sv
module sim_pfd_tristate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic err_oe, err_lvl, lock_pulse, xor_err, sr_err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pfd_tristate u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .err_oe(err_oe), .err_lvl(err_lvl), .lock_pulse(lock_pulse),
    .xor_err(xor_err), .sr_err(sr_err)
  );

  // {ref, fb, exp_oe, exp_lvl, exp_lock, exp_sr}; each held four clocks
  localparam int NV = 23;
  localparam logic [5:0] VEC [NV] = '{
    6'b00_0010, // idle
    6'b10_1101, // R3 ref first -> up
    6'b00_1101, // R6 ref falls, still up
    6'b01_0010, // R3 fb releases
    6'b00_0010,
    6'b01_1000, // R4 fb first -> down
    6'b00_1000, // R6
    6'b01_1000, // R5 no reference, stays down
    6'b00_1000,
    6'b10_0011, // R4 ref releases
    6'b00_0011,
    6'b11_0011, // R8 both, released, R10 sr holds 1
    6'b00_0011,
    6'b01_1000, // R4 down, R10 sr cleared
    6'b00_1000,
    6'b11_0010, // R8 both from down -> released, sr holds 0
    6'b00_0010,
    6'b10_1101, // R3 up
    6'b00_1101,
    6'b10_1101, // R5 extra ref edge keeps up
    6'b00_1101,
    6'b01_0010, // R3 release
    6'b00_0010
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 err_oe", err_oe, 1'b0);
    chk("R1 err_lvl", err_lvl, 1'b0);
    chk("R1 lock_pulse", lock_pulse, 1'b1);
    chk("R1 sr_err", sr_err, 1'b0);

    for (int v = 0; v < NV; v++) begin
      ref_in = VEC[v][5];
      fb_in  = VEC[v][4];
      cyc(4);
      chk($sformatf("R3/R4 oe v%0d", v), err_oe, VEC[v][3]);
      chk($sformatf("R3/R4 lvl v%0d", v), err_lvl, VEC[v][2]);
      chk($sformatf("R7 lock v%0d", v), lock_pulse, VEC[v][1]);
      chk($sformatf("R10 sr v%0d", v), sr_err, VEC[v][0]);
      chk($sformatf("R9 xor v%0d", v), xor_err, VEC[v][5] ^ VEC[v][4]);
    end

    // R2 latency: driven at a falling edge, main output moves on 3rd rising edge
    ref_in = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk("R2 oe after 2 edges", err_oe, 1'b0);
    chk("R2 xor after 2 edges", xor_err, 1'b1);
    @(posedge clk); #1;
    chk("R2 oe after 3 edges", err_oe, 1'b1);
    chk("R2 sr after 3 edges", sr_err, 1'b1);

    // R1 reset while driving
    cyc(1);
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    ref_in = 1'b0;
    cyc(1);
    chk("R1 oe after mid reset", err_oe, 1'b0);
    chk("R1 lock after mid reset", lock_pulse, 1'b1);
    chk("R1 sr after mid reset", sr_err, 1'b0);
    cyc(4);

    // R11 one-cycle reference glitch
    ref_in = 1'b1;
    cyc(1);
    ref_in = 1'b0;
    cyc(20);
    chk("R11 glitch oe", err_oe, 1'b1);
    chk("R11 glitch lvl", err_lvl, 1'b1);
    fb_in = 1'b1;
    cyc(4);
    chk("R11 released by fb", err_oe, 1'b0);
    fb_in = 1'b0;
    cyc(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule